// File: doc/BRIEF.md
# Block-Select Adder with Optional Increment Form

A combinational adder that splits a `WIDTH`-bit word into consecutive blocks. Block widths grow along the word: block k is `BLK_FIRST + k*BLK_STEP` bits wide, and the most significant block is cut short at the word edge. Each block outside the lowest finds its result before its real carry-in is known. That late carry then picks the correct result, so the carry crosses each block through a single multiplexer and does not ripple through the block's bits.

Parameter `INCR_MODE` selects how each block is built. With `INCR_MODE = 0`, each block has two complete ripple adders, one for carry-in 0 and one for carry-in 1, and a multiplexer picks one sum and one carry-out. With `INCR_MODE = 1`, the per-bit propagate/generate terms and the final sum XORs are built once for the whole word. Each block then forms only its carry-0 prefix generates, and combines each of them with the prefix propagate and the block's carry-in. Both forms produce the same outputs.

Top module: `csel_adder`

## Requirements
- R1: `{c_o, sum_o}` equals `a_i + b_i + c_i` as a `WIDTH+1`-bit unsigned sum, for every input and in both modes.
- R2: the carry entering each block equals the carry into that block's least significant bit in the true sum. This is the carry-0 block result when that carry is 0 and the carry-1 block result when it is 1.
- R3: with `a_i` and `b_i` all zeros, `sum_o` equals `c_i` in bit 0 with every other bit 0, and `c_o` is 0.
- R4: with `a_i` all ones, `b_i` zero and `c_i = 1`, `sum_o` is all zeros and `c_o` is 1, because the carry crosses every block.
- R5: with alternating bits (`a_i` = ...0101, `b_i` = ...1010), `sum_o` is all ones and `c_o` equals `c_i` when `c_i = 0`. When `c_i = 1`, `sum_o` is zero and `c_o` is 1.
- R6: an instance with `INCR_MODE = 1` and one with `INCR_MODE = 0`, driven by the same inputs, give identical `sum_o` and `c_o`.
- R7: block k starts at bit `sum(BLK_FIRST + j*BLK_STEP, j<k)`. A carry generated in the top bit of any block sets the lowest sum bit of the next block.
- R8: the lowest block takes `c_i` directly. With `a_i = b_i = 0`, only bit 0 of `sum_o` follows `c_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | first addend |
| b_i | input | WIDTH | second addend |
| c_i | input | 1 | carry into bit 0 |
| sum_o | output | WIDTH | sum |
| c_o | output | 1 | carry out of the top bit |

## Verification
The bench builds the adder with `WIDTH = 24`, `BLK_FIRST = 2` and `BLK_STEP = 1`, in both modes side by side. This gives blocks of 2, 3, 4, 5 and 6 bits, and then a top block that the word edge cuts from 7 bits to 4. Variable block size and truncation are therefore both exercised. Carries placed at the top of each block test every block boundary. The all-ones, all-zeros and alternating-bit vectors drive the full-propagate path across all six blocks.

// File: rtl/csa_pkg.sv
package csa_pkg;
  function automatic int blk_raw_w(int k, int first, int step);
    return first + k * step;
  endfunction

  function automatic int blk_count(int width, int first, int step);
    int acc = 0;
    int n = 0;
    while (acc < width) begin
      acc += blk_raw_w(n, first, step);
      n++;
    end
    return n;
  endfunction

  function automatic int blk_lsb(int k, int first, int step);
    int acc = 0;
    for (int j = 0; j < k; j++) acc += blk_raw_w(j, first, step);
    return acc;
  endfunction

  function automatic int blk_w(int k, int width, int first, int step);
    int raw = blk_raw_w(k, first, step);
    int rem = width - blk_lsb(k, first, step);
    return (raw < rem) ? raw : rem;
  endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  logic [W:0] c;

  always_comb begin
    c[0] = c_i;
    for (int i = 0; i < W; i++) begin
      sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
      c[i+1]   = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & c[i]);
    end
  end

  assign c_o = c[W];
endmodule

// File: rtl/csa_sel_block.sv
module csa_sel_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  logic [W-1:0] sum_z, sum_n;
  logic         c_z, c_n;

  csa_ripple #(.W(W)) i_rip_z (.a_i(a_i), .b_i(b_i), .c_i(1'b0), .sum_o(sum_z), .c_o(c_z));
  csa_ripple #(.W(W)) i_rip_n (.a_i(a_i), .b_i(b_i), .c_i(1'b1), .sum_o(sum_n), .c_o(c_n));

  // late carry only steers the mux
  assign sum_o = c_i ? sum_n : sum_z;
  assign c_o   = c_i ? c_n   : c_z;
endmodule

// File: rtl/csa_inc_block.sv
module csa_inc_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         c_i,
  output logic [W-1:0] carry_o,
  output logic         c_o
);
  logic [W:0] grp_g, grp_p;

  // carry-0 prefix group generate and group propagate from block lsb
  always_comb begin
    grp_g[0] = 1'b0;
    grp_p[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      grp_g[i+1] = g_i[i] | (p_i[i] & grp_g[i]);
      grp_p[i+1] = p_i[i] & grp_p[i];
    end
  end

  // increment: G(i-1:j) | P(i-1:j) & Cj
  assign carry_o = grp_g[W-1:0] | (grp_p[W-1:0] & {W{c_i}});
  assign c_o     = grp_g[W] | (grp_p[W] & c_i);
endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csa_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int BLK_FIRST = 4,
  parameter int BLK_STEP  = 0,
  parameter bit INCR_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);
  localparam int NBLK = blk_count(WIDTH, BLK_FIRST, BLK_STEP);

  logic [NBLK:0] blk_c;

  assign blk_c[0] = c_i;
  assign c_o      = blk_c[NBLK];

  if (INCR_MODE) begin : g_inc
    logic [WIDTH-1:0] p, g, cvec;

    assign p     = a_i ^ b_i;
    assign g     = a_i & b_i;
    assign sum_o = p ^ cvec;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
      localparam int LSB = blk_lsb(k, BLK_FIRST, BLK_STEP);
      localparam int W   = blk_w(k, WIDTH, BLK_FIRST, BLK_STEP);
      csa_inc_block #(.W(W)) i_blk (
        .p_i    (p[LSB +: W]),
        .g_i    (g[LSB +: W]),
        .c_i    (blk_c[k]),
        .carry_o(cvec[LSB +: W]),
        .c_o    (blk_c[k+1])
      );
    end
  end else begin : g_sel
    for (genvar k = 0; k < NBLK; k++) begin : g_blk
      localparam int LSB = blk_lsb(k, BLK_FIRST, BLK_STEP);
      localparam int W   = blk_w(k, WIDTH, BLK_FIRST, BLK_STEP);
      if (k == 0) begin : g_first
        csa_ripple #(.W(W)) i_rip (
          .a_i  (a_i[LSB +: W]),
          .b_i  (b_i[LSB +: W]),
          .c_i  (blk_c[k]),
          .sum_o(sum_o[LSB +: W]),
          .c_o  (blk_c[k+1])
        );
      end else begin : g_rest
        csa_sel_block #(.W(W)) i_sel (
          .a_i  (a_i[LSB +: W]),
          .b_i  (b_i[LSB +: W]),
          .c_i  (blk_c[k]),
          .sum_o(sum_o[LSB +: W]),
          .c_o  (blk_c[k+1])
        );
      end
    end
  end
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk
  import csa_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int BLK_FIRST = 4,
  parameter int BLK_STEP  = 0,
  parameter int NBLK      = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             c_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             c_o,
  input logic [NBLK:0]    blk_c
);
  logic [WIDTH:0]   tot;
  logic [WIDTH-1:0] cin_vec;

  always_comb begin
    tot     = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i};
    cin_vec = tot[WIDTH-1:0] ^ a_i ^ b_i;

    // R1
    sum_total_chk: assert ({c_o, sum_o} == tot);

    // R2
    for (int k = 1; k < NBLK; k++) begin
      blk_carry_chk: assert (blk_c[k] == cin_vec[blk_lsb(k, BLK_FIRST, BLK_STEP)]);
    end

    // R3 R8
    if (a_i == '0 && b_i == '0) begin
      zero_add_chk: assert (sum_o == WIDTH'(c_i) && !c_o);
    end

    // R4 R5
    if ((a_i ^ b_i) == '1) begin
      full_prop_chk: assert (c_o == c_i && sum_o == {WIDTH{~c_i}});
    end
  end
endmodule

bind csel_adder csel_adder_chk #(
  .WIDTH(WIDTH), .BLK_FIRST(BLK_FIRST), .BLK_STEP(BLK_STEP), .NBLK(NBLK)
) i_csel_adder_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .sum_o(sum_o), .c_o(c_o), .blk_c(blk_c)
);

// File: tb/test_csel_adder.sv
module test_csel_adder;
  localparam int WIDTH = 24;
  localparam int FIRST = 2;
  localparam int STEP  = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [WIDTH-1:0] a, b, sum_s, sum_i;
  logic c, co_s, co_i;
  int n_chk = 0;
  int n_ok = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csel_adder #(.WIDTH(WIDTH), .BLK_FIRST(FIRST), .BLK_STEP(STEP), .INCR_MODE(1'b0)) i_csel_adder (
    .a_i(a), .b_i(b), .c_i(c), .sum_o(sum_s), .c_o(co_s));
  csel_adder #(.WIDTH(WIDTH), .BLK_FIRST(FIRST), .BLK_STEP(STEP), .INCR_MODE(1'b1)) i_csel_adder_inc (
    .a_i(a), .b_i(b), .c_i(c), .sum_o(sum_i), .c_o(co_i));

  function automatic logic [WIDTH:0] ref_add(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  task automatic check(string req, logic [WIDTH:0] got, logic [WIDTH:0] exp);
    n_chk++;
    if (got === exp) n_ok++;
    else $display("FAIL %s: got %h expected %h (a=%h b=%h c=%b)", req, got, exp, a, b, c);
  endtask

  task automatic apply(string req, logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic ci,
                       logic [WIDTH:0] exp);
    @(posedge clk);
    a = x; b = y; c = ci;
    @(negedge clk);
    check({req, " sel"}, {co_s, sum_s}, exp);
    check({req, " inc"}, {co_i, sum_i}, exp);
    // R6
    check("R6", {co_i, sum_i}, {co_s, sum_s});
  endtask

  initial begin
    a = '0; b = '0; c = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R3 reset", {co_s, sum_s}, '0);

    // R3 R8: carry-in lands only in bit 0
    apply("R3", '0, '0, 1'b0, '0);
    apply("R8", '0, '0, 1'b1, (WIDTH+1)'(1));
    // R4: carry crosses every block
    apply("R4", '1, '0, 1'b1, {1'b1, {WIDTH{1'b0}}});
    apply("R4", '1, '1, 1'b1, {1'b1, {WIDTH{1'b1}}});
    apply("R4", '1, '1, 1'b0, {1'b1, {(WIDTH-1){1'b1}}, 1'b0});
    // R5: alternating bits
    apply("R5", {(WIDTH/2){2'b01}}, {(WIDTH/2){2'b10}}, 1'b0, {1'b0, {WIDTH{1'b1}}});
    apply("R5", {(WIDTH/2){2'b01}}, {(WIDTH/2){2'b10}}, 1'b1, {1'b1, {WIDTH{1'b0}}});
    apply("R5", {(WIDTH/2){2'b10}}, {(WIDTH/2){2'b10}}, 1'b0, ref_add({(WIDTH/2){2'b10}}, {(WIDTH/2){2'b10}}, 1'b0));

    // R7 R2: carry from top bit of each block into the next
    begin
      int lsb = 0;
      int k = 0;
      while (lsb + FIRST + k * STEP < WIDTH) begin
        lsb += FIRST + k * STEP;
        k++;
        apply("R7", WIDTH'(1) << (lsb - 1), WIDTH'(1) << (lsb - 1), 1'b0,
              (WIDTH+1)'(1) << lsb);
        apply("R2", (WIDTH'(1) << lsb) - 1, '0, 1'b1, (WIDTH+1)'(1) << lsb);
      end
    end

    // R1: random vectors
    void'($urandom(32'd4242));
    for (int i = 0; i < 400; i++) begin
      logic [WIDTH-1:0] x, y;
      logic ci;
      x  = WIDTH'($urandom);
      y  = WIDTH'($urandom);
      ci = 1'($urandom);
      apply("R1", x, y, ci, ref_add(x, y, ci));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_ok, n_chk);
      $finish;
    end
  end
endmodule